// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits behind an asynchronous-style parallel memory bus and turns the write cycles on that bus into operating modes for a small flash-like storage array. A write cycle ends on the rising edge of the write strobe while the chip is selected. The block then reads the data byte as a command, or as the second byte of a two-cycle command. The block tracks whether reads return array contents or its status byte. It starts a simplified internal write engine that programs one word or wipes one block, and it lets an erase be paused and later continued.

All bus inputs are sampled on the system clock. The edges of the write strobe are found in the clock domain. Read data leaves the block one clock after the read conditions are presented, and an enable flag marks it as valid. An active-low device reset pin behaves like a functional reset. When it is released, the block is back in array-read mode without any command.

Top module: `flash_cmd_if`

## Requirements
- R1: While the device reset pin `rp_n` is low, or `rst` is high, the mode returns to array read, the engine stops, the suspend flag clears and both error bits clear. After release, reads return array data with no command.
- R2: `dout_en` is high in a cycle only if the previous clock edge saw `ce_n`=0, `oe_n`=0, `we_n`=1 and `rp_n`=1. Otherwise `dout` is 0.
- R3: Command 0xFF selects array mode. Reads in this mode return the stored word at `addr`.
- R4: Command 0x40 or 0x10 arms program. The next write cycle latches `addr` and `din`, and the word is stored PROG_CYC clocks later.
- R5: After a program or erase starts, reads return the status byte until a 0xFF command is accepted, including after the engine finishes.
- R6: Command 0x20 followed by 0xD0 erases the block selected by `addr[ADDR_W-1:BLK_W]` to all ones, one word per unpaused clock over 2^BLK_W clocks. Other blocks keep their contents.
- R7: After 0x20, any second byte other than 0xD0 sets status bits 5 and 4, selects status mode and starts nothing.
- R8: While the engine is running and not paused, reads return status with bit 7 = 0. Only 0x70 (status mode) and 0xB0 (erase pause) are acted on in that state.
- R9: The status byte holds bit 7 = ready, bit 6 = erase paused, bit 5 = erase error and bit 4 = program error, with bits 3:0 = 0. Command 0x50 clears bits 5 and 4.
- R10: Command 0xB0 during an erase freezes the erase counter and sets bit 6 and bit 7. A following 0xFF then allows array reads.
- R11: Command 0xD0 while an erase is paused resumes it and selects status mode.
- R12: Reserved and unknown codes (for example 0x60 and 0x98) leave the mode and the array unchanged. 0x40, 0x10 and 0x20 are ignored while an erase is paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_n | input | 1 | Device reset pin, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; the cycle ends on its rise |
| oe_n | input | 1 | Read enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Command or program data |
| dout | output | DATA_W | Read data (array word or status byte) |
| dout_en | output | 1 | Read data valid |

## Verification
A scoreboard queues an expected byte for every read cycle and compares it with the byte the block returns. The reads cover several kinds of write sequence:
- Well-formed two-cycle program sequences with each of the two set-up codes. These show that both codes arm the same path.
- An erase set-up followed by a wrong confirm. This separates the error path from a real erase.
- Reserved codes placed between valid ones. These show they do not disturb the mode.
- An erase that is paused, read from and resumed, with a 0xFF written while it is busy. This separates commands that are ignored while busy from those that are honoured.
- A program left in status mode and then cut off by the reset pin. This shows that array mode returns without a command.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [1:0] {
    MD_ARRAY,
    MD_STATUS,
    MD_PSETUP,
    MD_ESETUP
  } mode_e;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_PROG,
    EN_ERASE
  } eng_e;

  localparam logic [7:0] CMD_READ     = 8'hFF;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_CLEAR    = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

  function automatic int cnt_width(input int prog_cyc, input int blk_w);
    int pw;
    pw = $clog2(prog_cyc);
    return ((pw > blk_w) ? pw : blk_w) + 1;
  endfunction

endpackage

// File: rtl/fci_bus_strobe.sv
module fci_bus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic rp_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_stb,
  output logic rd_act
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  // a write cycle closes on the rising strobe while selected
  assign wr_stb = rp_n & ~ce_n & we_n & ~we_q;
  assign rd_act = rp_n & ~ce_n & ~oe_n & we_n;
endmodule

// File: rtl/fci_array.sv
module fci_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fci_cmd_fsm.sv
module fci_cmd_fsm
  import fci_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BLK_W    = 4,
  parameter int PROG_CYC = 5,
  parameter int CNT_W    = cnt_width(PROG_CYC, BLK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rp_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output mode_e             mode,
  output logic              busy,
  output logic              susp,
  output logic [DATA_W-1:0] status,
  output logic [CNT_W-1:0]  cnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int BLK_WORDS = 1 << BLK_W;
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(BLK_WORDS - 1);

  eng_e              eng;
  logic              err_e, err_p;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [7:0]        cmd;

  assign cmd  = din[7:0];
  assign busy = (eng != EN_IDLE) && !susp;

  always_ff @(posedge clk) begin
    if (rst || !rp_n) begin
      mode     <= MD_ARRAY;
      eng      <= EN_IDLE;
      susp     <= 1'b0;
      err_e    <= 1'b0;
      err_p    <= 1'b0;
      cnt      <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      // engine progress
      if (eng == EN_PROG) begin
        if (cnt == '0) eng <= EN_IDLE;
        else           cnt <= cnt - 1'b1;
      end else if (eng == EN_ERASE && !susp) begin
        if (cnt == ERASE_LAST) eng <= EN_IDLE;
        cnt <= cnt + 1'b1;
      end
      // command decode
      if (wr_stb) begin
        case (mode)
          MD_PSETUP: begin
            lat_addr <= addr;
            lat_data <= din;
            eng      <= EN_PROG;
            cnt      <= PROG_LOAD;
            mode     <= MD_STATUS;
          end
          MD_ESETUP: begin
            if (cmd == CMD_CONFIRM) begin
              lat_addr <= addr;
              eng      <= EN_ERASE;
              cnt      <= '0;
            end else begin
              err_e <= 1'b1;
              err_p <= 1'b1;
            end
            mode <= MD_STATUS;
          end
          default: begin
            if (busy) begin
              if (cmd == CMD_STATUS) mode <= MD_STATUS;
              else if (cmd == CMD_SUSPEND && eng == EN_ERASE && cnt != ERASE_LAST)
                susp <= 1'b1;
            end else begin
              case (cmd)
                CMD_READ:    mode <= MD_ARRAY;
                CMD_STATUS:  mode <= MD_STATUS;
                CMD_CLEAR:   begin err_e <= 1'b0; err_p <= 1'b0; end
                CMD_PROG,
                CMD_PROG_ALT: if (!susp) mode <= MD_PSETUP;
                CMD_ERASE:   if (!susp) mode <= MD_ESETUP;
                CMD_CONFIRM: if (susp) begin susp <= 1'b0; mode <= MD_STATUS; end
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    status    = '0;
    status[7] = ~busy;
    status[6] = susp;
    status[5] = err_e;
    status[4] = err_p;
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = lat_addr;
    mem_wdata = lat_data;
    if (!rst && rp_n) begin
      if (eng == EN_PROG && cnt == '0) mem_we = 1'b1;
      else if (eng == EN_ERASE && !susp) begin
        mem_we    = 1'b1;
        mem_waddr = {lat_addr[ADDR_W-1:BLK_W], cnt[BLK_W-1:0]};
        mem_wdata = '1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BLK_W    = 4,
  parameter int PROG_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rp_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int CNT_W = cnt_width(PROG_CYC, BLK_W);

  logic              wr_stb, rd_act;
  mode_e             mode;
  logic              busy, susp;
  logic [DATA_W-1:0] status;
  logic [CNT_W-1:0]  cnt;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] arr_q, stat_q;
  logic              sel_q;

  fci_bus_strobe u_strobe (
    .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_stb(wr_stb), .rd_act(rd_act)
  );

  fci_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .rp_n(rp_n), .wr_stb(wr_stb), .addr(addr), .din(din),
    .mode(mode), .busy(busy), .susp(susp), .status(status), .cnt(cnt),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  fci_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr), .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= 1'b0;
      sel_q   <= 1'b0;
      stat_q  <= '0;
    end else begin
      dout_en <= rd_act;
      sel_q   <= (mode != MD_ARRAY) || busy;
      stat_q  <= status;
    end
  end

  assign dout = dout_en ? (sel_q ? stat_q : arr_q) : '0;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rp_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              busy,
  input logic              susp,
  input logic              wr_stb,
  input logic [DATA_W-1:0] status,
  input logic [CNT_W-1:0]  cnt
);
  // R2
  read_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !we_n || !rp_n) |=> !dout_en);

  // R1
  pin_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !rp_n |=> (!busy && !susp && status[7:4] == 4'h8));

  // R8
  busy_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !ce_n && !oe_n && we_n && rp_n) |=> (dout_en && !dout[7]));

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst || !rp_n)
    (susp && !wr_stb) |=> $stable(cnt));

  // R11
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (susp && wr_stb && din[7:0] == 8'hD0) |=> !susp);
endmodule

bind flash_cmd_if flash_cmd_if_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .din(din), .dout(dout), .dout_en(dout_en), .busy(busy), .susp(susp),
  .wr_stb(wr_stb), .status(status), .cnt(cnt)
);

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;
  logic       clk = 1'b0;
  logic       rst, rp_n, ce_n, we_n, oe_n;
  logic [7:0] addr, din;
  logic [7:0] dout;
  logic       dout_en;
  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  flash_cmd_if u_flash_cmd_if (
    .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  // driver: push the expected byte, then run the read cycle
  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  // monitor: every valid read byte is matched against the queue head
  initial begin
    forever begin
      @(posedge clk); #3;
      if (dout_en) begin
        if (exp_q.size() == 0) chk("R2 unexpected read", 8'h01, 8'h00);
        else chk(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    rst = 1; rp_n = 1; ce_n = 1; we_n = 1; oe_n = 1; addr = 0; din = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset dout_en", {7'd0, dout_en}, 8'h00);
    chk("R2 reset dout", dout, 8'h00);

    wr(8'h00, 8'h70); rd(8'h00, 8'h80, "R9 idle status");

    // program through the primary code
    wr(8'h12, 8'h40); wr(8'h12, 8'h5A);
    rd(8'h12, 8'h00, "R8 read while programming");
    repeat (10) @(negedge clk);
    rd(8'h12, 8'h80, "R5 status after program");
    wr(8'h00, 8'hFF); rd(8'h12, 8'h5A, "R3 R4 programmed word");

    // alternate program code
    wr(8'h13, 8'h10); wr(8'h13, 8'hC3);
    repeat (10) @(negedge clk);
    wr(8'h00, 8'hFF); rd(8'h13, 8'hC3, "R4 alternate code");

    // wrong erase confirm, then clear
    wr(8'h00, 8'h20); wr(8'h00, 8'h77);
    rd(8'h00, 8'hB0, "R7 bad confirm bits");
    wr(8'h00, 8'h50); rd(8'h00, 8'h80, "R9 clear status");

    // reserved codes ignored
    wr(8'h00, 8'hFF); wr(8'h00, 8'h60); rd(8'h12, 8'h5A, "R12 code 60");
    wr(8'h00, 8'h98); rd(8'h13, 8'hC3, "R12 code 98");

    // word in another block
    wr(8'h25, 8'h40); wr(8'h25, 8'h11);
    repeat (10) @(negedge clk);
    wr(8'h00, 8'hFF);

    // erase block 1 with pause and resume
    wr(8'h00, 8'h20); wr(8'h15, 8'hD0);
    wr(8'h00, 8'hFF);
    rd(8'h12, 8'h00, "R8 busy ignores read-array");
    wr(8'h00, 8'hB0); rd(8'h12, 8'hC0, "R10 paused status");
    wr(8'h00, 8'hFF); rd(8'h25, 8'h11, "R10 array read while paused");
    wr(8'h00, 8'h40); rd(8'h25, 8'h11, "R12 program ignored while paused");
    wr(8'h00, 8'hD0); rd(8'h00, 8'h00, "R11 resumed busy");
    repeat (30) @(negedge clk);
    rd(8'h00, 8'h80, "R5 status after erase");
    wr(8'h00, 8'hFF);
    rd(8'h12, 8'hFF, "R6 erased word");
    rd(8'h1F, 8'hFF, "R6 erased last word");
    rd(8'h25, 8'h11, "R6 other block kept");

    // reset pin returns to array mode
    wr(8'h12, 8'h40); wr(8'h12, 8'h3C);
    repeat (10) @(negedge clk);
    @(negedge clk); rp_n = 0; ce_n = 0; oe_n = 0;
    @(negedge clk); chk("R2 no read while rp_n low", {7'd0, dout_en}, 8'h00);
    ce_n = 1; oe_n = 1; rp_n = 1;
    rd(8'h12, 8'h3C, "R1 array mode after pin reset");

    // read enable without chip select
    @(negedge clk); ce_n = 1; oe_n = 0;
    @(negedge clk); chk("R2 deselected", {7'd0, dout_en}, 8'h00);
    oe_n = 1;

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
    summary();
  end
endmodule